// File: doc/BRIEF.md
# CCD horizontal clock and blanking generator

This block times one line of a CCD readout. It keeps a 13-bit pixel counter that an active-low line strobe restarts. The strobe first crosses into the pixel-clock domain through two flops. The restart comes a fixed number of cycles after the strobe's falling edge is seen. From the counter it derives three pulse outputs at programmable counter positions. The first is a dark-level clamp pulse. The second is a pre-blank pulse. The third is a horizontal blank window, which uses one set of positions on odd lines and another set on even lines.

The block also drives four horizontal shift clocks, H1 to H4. A 3-bit mode code selects how the four phases relate to each other. While the blank window is open, the clocks either park at two programmable levels or slow down by an even factor. The slowed clock starts in a fixed phase at the opening edge of the window. Every configuration input is static and is changed only between lines.

Top module: `hbg_top`

## Requirements
- R1: While reset is held, every output is 0. After reset, clamp, pre-blank and blank stay 0 until the first line start, and the error flag is 0.
- R2: The strobe is sampled on rising clock edges. If it is sampled low at edge n after a high sample at edge n-1, the line restarts at edge n+13. At that edge clamp takes its start polarity, pre-blank takes its start polarity, blank goes to 0, the counter becomes 0 and the parity input is latched.
- R3: A position p flips its output at edge n+14+p (it matches the counter value p of the edge before). Matches that would take effect at edges n+2 through n+13 are dropped, so toggle positions inside the 12-cycle restart window never fire.
- R4: Clamp and pre-blank each have two toggle positions. Each position that matches flips the output. Two positions with the same value cancel each other.
- R5: Blank has six positions, each with its own enable bit, for odd lines (latched parity 1) and six more for even lines (parity 0). Each enabled position that matches flips blank.
- R6: Outside blank, a base clock inverts on every edge. With G1, G2 and G3 equal to the base clock XOR the phase bits a, b and c, the outputs are: mode 001 gives H1=H3=G1 and H2=H4=~G1; mode 010 gives H1=H3=G1 and H2=H4=G2; mode 100 gives H1=G1, H3=G3, H2=~G1 and H4=~G3. Output bit 0 is H1 and bit 3 is H4.
- R7: While blank is 1 and the wide setting is 0, H1 and H3 equal the first mask level and H2 and H4 equal the second mask level.
- R8: While blank is 1 and the wide setting W is 1 to 15, the base clock is forced to 0 on the edge that blank rises. It then inverts every 2W edges, which gives a clock period of 4W pixel clocks. The mode relations of R6 still apply.
- R9: Any mode code other than 001, 010 or 100 drives all four H outputs to 0 from the next edge and sets the error flag. The flag stays set until reset.
- R10: The H outputs switch to their blank behaviour on the same edge on which blank rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| line_sync_n | input | 1 | Active-low line strobe, asynchronous |
| field_odd | input | 1 | Line parity: 1 selects the odd blank set |
| cfg_hmode | input | 3 | H clock mode code |
| cfg_ph_a | input | 1 | Phase bit of G1 |
| cfg_ph_b | input | 1 | Phase bit of G2 |
| cfg_ph_c | input | 1 | Phase bit of G3 |
| cfg_mask_13 | input | 1 | Level of H1/H3 during blank |
| cfg_mask_24 | input | 1 | Level of H2/H4 during blank |
| cfg_wide | input | 4 | Wide-clock setting, 0 disables |
| cfg_clp_pol | input | 1 | Clamp start polarity |
| cfg_clp_pos | input | 26 | Two clamp positions, 13 bits each |
| cfg_pblk_pol | input | 1 | Pre-blank start polarity |
| cfg_pblk_pos | input | 26 | Two pre-blank positions |
| cfg_hb_odd_pos | input | 78 | Six odd-line blank positions |
| cfg_hb_odd_en | input | 6 | Enable bits of the odd positions |
| cfg_hb_even_pos | input | 78 | Six even-line blank positions |
| cfg_hb_even_en | input | 6 | Enable bits of the even positions |
| clamp_o | output | 1 | Clamp pulse |
| preblank_o | output | 1 | Pre-blank pulse |
| hblank_o | output | 1 | Horizontal blank window |
| hclk_o | output | 4 | H1 (bit 0) to H4 (bit 3) |
| mode_err_o | output | 1 | Sticky invalid-mode flag |

## Verification
The hardest case to reach is a toggle position that the previous line's counter passes after the next strobe edge but before the restart. To get there, the bench uses lines exactly 100 cycles long and places both clamp positions at counter values 88 to 99. That puts the matches inside the 12-edge window, so the clamp must never leave its start level. The wide-clock phase reset is exercised by blank windows that open at different base-clock phases, with W set to 1 and to 3. A behavioural model built on integers follows every output on every cycle.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    localparam int PIX_W = 13;

    typedef enum logic [2:0] {
        HM_PAIR = 3'b001,
        HM_DUAL = 3'b010,
        HM_QUAD = 3'b100
    } hmode_e;

    function automatic logic mode_ok(input logic [2:0] m);
        return (m == HM_PAIR) || (m == HM_DUAL) || (m == HM_QUAD);
    endfunction
endpackage

// File: rtl/hbg_line_timer.sv
module hbg_line_timer #(
    parameter int CW      = 13,
    parameter int RST_DLY = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_n,
    input  logic          parity_in,
    output logic [CW-1:0] cnt_q,
    output logic          match_en,
    output logic          restart,
    output logic          par_q
);
    localparam int DW = $clog2(RST_DLY);
    localparam logic [CW-1:0] CMAX  = '1;
    localparam logic [DW-1:0] DLOAD = DW'(RST_DLY - 2);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        logic          busy;
        logic [DW-1:0] dly;
        logic [CW-1:0] cnt;
        logic          run;
        logic          par;
    } lt_t;

    lt_t st_d, st_q;
    logic fall;

    always_comb begin
        st_d    = st_q;
        fall    = st_q.prev & ~st_q.s2;
        restart = st_q.busy && (st_q.dly == '0) && !fall;
        match_en = st_q.run && !st_q.busy && !fall;

        st_d.s1   = sync_n;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;

        if (st_q.run) begin
            if (st_q.cnt == CMAX) st_d.run = 1'b0;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end

        if (fall) begin
            st_d.busy = 1'b1;
            st_d.dly  = DLOAD;
        end else if (restart) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
            st_d.run  = 1'b1;
            st_d.par  = parity_in;
        end else if (st_q.busy) begin
            st_d.dly = st_q.dly - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, busy: 1'b0, dly: '0,
                      cnt: '0, run: 1'b0, par: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign par_q = st_q.par;

    // R2
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0) && st_q.run);

    // R3
    busy_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> st_q.busy && !match_en);
endmodule

// File: rtl/hbg_toggle_gen.sv
module hbg_toggle_gen #(
    parameter int NT = 2,
    parameter int CW = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             match_en,
    input  logic             start_lvl,
    input  logic [CW-1:0]    cnt,
    input  logic [NT*CW-1:0] pos,
    input  logic [NT-1:0]    used,
    output logic             lvl_q,
    output logic             lvl_nxt
);
    typedef struct packed {
        logic lvl;
    } tg_t;

    tg_t st_d, st_q;
    logic [NT-1:0] hit;

    for (genvar g = 0; g < NT; g++) begin : g_hit
        assign hit[g] = used[g] && (pos[g*CW +: CW] == cnt);
    end

    always_comb begin
        st_d = st_q;
        if (restart)       st_d.lvl = start_lvl;
        else if (match_en) st_d.lvl = st_q.lvl ^ (^hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: 1'b0};
        else        st_q <= st_d;
    end

    assign lvl_q   = st_q.lvl;
    assign lvl_nxt = st_d.lvl;

    // R4
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !match_en) |=> $stable(lvl_q));

    // R2
    restart_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (lvl_q == $past(start_lvl)));
endmodule

// File: rtl/hbg_hclk.sv
module hbg_hclk #(
    parameter int WIDE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_cur,
    input  logic              hb_nxt,
    input  logic [2:0]        mode,
    input  logic [WIDE_W-1:0] wide,
    input  logic              ph_a,
    input  logic              ph_b,
    input  logic              ph_c,
    input  logic              m13,
    input  logic              m24,
    output logic [3:0]        h_q,
    output logic              err_q
);
    import hbg_pkg::*;

    localparam int DVW = WIDE_W + 1;

    typedef struct packed {
        logic           base;
        logic [DVW-1:0] div;
        logic [3:0]     h;
        logic           err;
    } hc_t;

    hc_t st_d, st_q;
    logic [DVW-1:0] span;
    logic g1, g2, g3, valid;

    always_comb begin
        st_d  = st_q;
        span  = {wide, 1'b0} - DVW'(1);
        valid = mode_ok(mode);

        if (hb_nxt && !hb_cur) begin
            st_d.base = 1'b0;
            st_d.div  = '0;
        end else if (hb_nxt && (wide != '0)) begin
            if (st_q.div == span) begin
                st_d.div  = '0;
                st_d.base = ~st_q.base;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end else begin
            st_d.base = ~st_q.base;
            st_d.div  = '0;
        end

        g1 = st_d.base ^ ph_a;
        g2 = st_d.base ^ ph_b;
        g3 = st_d.base ^ ph_c;

        case (mode)
            HM_PAIR: st_d.h = {~g1, g1, ~g1, g1};
            HM_DUAL: st_d.h = {g2, g1, g2, g1};
            HM_QUAD: st_d.h = {~g3, g3, ~g1, g1};
            default: st_d.h = 4'b0000;
        endcase

        if (!valid) st_d.err = 1'b1;
        else if (hb_nxt && (wide == '0)) st_d.h = {m24, m13, m24, m13};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{base: 1'b0, div: '0, h: 4'b0000, err: 1'b0};
        else        st_q <= st_d;
    end

    assign h_q   = st_q.h;
    assign err_q = st_q.err;

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R9
    bad_mode_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok(mode) |=> (h_q == 4'b0000) && err_q);

    // R7
    mask_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_nxt && hb_cur && (wide == '0) && mode_ok(mode)) |=> $stable(h_q));

    // R6
    pair_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hb_nxt && (mode == HM_PAIR)) |=> (h_q[2] == h_q[0]) && (h_q[1] == ~h_q[0]));
endmodule

// File: rtl/hbg_top.sv
module hbg_top #(
    parameter int CW     = 13,
    parameter int CP_NT  = 2,
    parameter int HB_NT  = 6,
    parameter int WIDE_W = 4,
    parameter int RST_DLY = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_sync_n,
    input  logic                field_odd,
    input  logic [2:0]          cfg_hmode,
    input  logic                cfg_ph_a,
    input  logic                cfg_ph_b,
    input  logic                cfg_ph_c,
    input  logic                cfg_mask_13,
    input  logic                cfg_mask_24,
    input  logic [WIDE_W-1:0]   cfg_wide,
    input  logic                cfg_clp_pol,
    input  logic [CP_NT*CW-1:0] cfg_clp_pos,
    input  logic                cfg_pblk_pol,
    input  logic [CP_NT*CW-1:0] cfg_pblk_pos,
    input  logic [HB_NT*CW-1:0] cfg_hb_odd_pos,
    input  logic [HB_NT-1:0]    cfg_hb_odd_en,
    input  logic [HB_NT*CW-1:0] cfg_hb_even_pos,
    input  logic [HB_NT-1:0]    cfg_hb_even_en,
    output logic                clamp_o,
    output logic                preblank_o,
    output logic                hblank_o,
    output logic [3:0]          hclk_o,
    output logic                mode_err_o
);
    logic [CW-1:0]       cnt;
    logic                match_en, restart, par;
    logic                hb_nxt, clp_nxt, pblk_nxt;
    logic [HB_NT*CW-1:0] hb_pos;
    logic [HB_NT-1:0]    hb_used;

    hbg_line_timer #(.CW(CW), .RST_DLY(RST_DLY)) u_timer (
        .clk(clk), .rst_n(rst_n), .sync_n(line_sync_n), .parity_in(field_odd),
        .cnt_q(cnt), .match_en(match_en), .restart(restart), .par_q(par)
    );

    hbg_toggle_gen #(.NT(CP_NT), .CW(CW)) u_clamp (
        .clk(clk), .rst_n(rst_n), .restart(restart), .match_en(match_en),
        .start_lvl(cfg_clp_pol), .cnt(cnt), .pos(cfg_clp_pos), .used('1),
        .lvl_q(clamp_o), .lvl_nxt(clp_nxt)
    );

    hbg_toggle_gen #(.NT(CP_NT), .CW(CW)) u_preblank (
        .clk(clk), .rst_n(rst_n), .restart(restart), .match_en(match_en),
        .start_lvl(cfg_pblk_pol), .cnt(cnt), .pos(cfg_pblk_pos), .used('1),
        .lvl_q(preblank_o), .lvl_nxt(pblk_nxt)
    );

    assign hb_pos  = par ? cfg_hb_odd_pos : cfg_hb_even_pos;
    assign hb_used = par ? cfg_hb_odd_en  : cfg_hb_even_en;

    hbg_toggle_gen #(.NT(HB_NT), .CW(CW)) u_blank (
        .clk(clk), .rst_n(rst_n), .restart(restart), .match_en(match_en),
        .start_lvl(1'b0), .cnt(cnt), .pos(hb_pos), .used(hb_used),
        .lvl_q(hblank_o), .lvl_nxt(hb_nxt)
    );

    hbg_hclk #(.WIDE_W(WIDE_W)) u_hclk (
        .clk(clk), .rst_n(rst_n), .hb_cur(hblank_o), .hb_nxt(hb_nxt),
        .mode(cfg_hmode), .wide(cfg_wide), .ph_a(cfg_ph_a), .ph_b(cfg_ph_b),
        .ph_c(cfg_ph_c), .m13(cfg_mask_13), .m24(cfg_mask_24),
        .h_q(hclk_o), .err_q(mode_err_o)
    );

    // R10
    blank_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hblank_o) && (cfg_wide == '0) && hbg_pkg::mode_ok(cfg_hmode)
         && $stable(cfg_hmode) && $stable(cfg_wide))
        |-> (hclk_o[0] == cfg_mask_13) && (hclk_o[1] == cfg_mask_24));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clp_nxt != clamp_o || pblk_nxt != preblank_o) |-> (restart || match_en));
endmodule

// File: tb/hbg_top_tb.sv
module hbg_top_tb;
    localparam int CW = 13;

    logic clk = 0, rst_n = 0, hd = 1, fodd = 0;
    logic [2:0] mode = 3'b001;
    logic pa = 0, pb = 0, pc = 0, mk13 = 0, mk24 = 0;
    logic [3:0] wide = 0;
    logic clp_pol = 0, pblk_pol = 0;
    logic [2*CW-1:0] clp_pos = 0, pblk_pos = 0;
    logic [6*CW-1:0] hbo_pos = 0, hbe_pos = 0;
    logic [5:0] hbo_en = 0, hbe_en = 0;
    logic clamp, pblk, hblank, merr;
    logic [3:0] hclk;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hbg_top u_dut (
        .clk(clk), .rst_n(rst_n), .line_sync_n(hd), .field_odd(fodd),
        .cfg_hmode(mode), .cfg_ph_a(pa), .cfg_ph_b(pb), .cfg_ph_c(pc),
        .cfg_mask_13(mk13), .cfg_mask_24(mk24), .cfg_wide(wide),
        .cfg_clp_pol(clp_pol), .cfg_clp_pos(clp_pos),
        .cfg_pblk_pol(pblk_pol), .cfg_pblk_pos(pblk_pos),
        .cfg_hb_odd_pos(hbo_pos), .cfg_hb_odd_en(hbo_en),
        .cfg_hb_even_pos(hbe_pos), .cfg_hb_even_en(hbe_en),
        .clamp_o(clamp), .preblank_o(pblk), .hblank_o(hblank),
        .hclk_o(hclk), .mode_err_o(merr)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit s1 = 1, s2 = 1, sp = 1;
    int wait_left = -1;
    int pix = 0;
    bit running = 0, lpar = 0;
    bit e_clp = 0, e_pblk = 0, e_hb = 0, base = 0, e_err = 0;
    int divc = 0;
    bit [3:0] e_h = 0;
    bit hb_rose = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            s1 = 1; s2 = 1; sp = 1; wait_left = -1; pix = 0; running = 0; lpar = 0;
            e_clp = 0; e_pblk = 0; e_hb = 0; base = 0; e_err = 0; divc = 0; e_h = 0;
            hb_rose = 0;
        end else begin
            bit seen_fall, begin_line, live, hb_old, g1, g2, g3;
            seen_fall  = sp && !s2;
            begin_line = (wait_left == 0) && !seen_fall;
            live       = running && (wait_left < 0) && !seen_fall;
            hb_old     = e_hb;
            if (begin_line) begin
                e_clp = clp_pol; e_pblk = pblk_pol; e_hb = 0;
            end else if (live) begin
                for (int i = 0; i < 2; i++) begin
                    if (int'(clp_pos[i*CW +: CW]) == pix)  e_clp = !e_clp;
                    if (int'(pblk_pos[i*CW +: CW]) == pix) e_pblk = !e_pblk;
                end
                for (int i = 0; i < 6; i++) begin
                    if (lpar && hbo_en[i] && int'(hbo_pos[i*CW +: CW]) == pix)   e_hb = !e_hb;
                    if (!lpar && hbe_en[i] && int'(hbe_pos[i*CW +: CW]) == pix) e_hb = !e_hb;
                end
            end
            if (running) begin
                if (pix == 8191) running = 0; else pix++;
            end
            if (seen_fall) wait_left = 10;
            else if (begin_line) begin
                wait_left = -1; pix = 0; running = 1; lpar = fodd;
            end else if (wait_left > 0) wait_left--;
            // horizontal clocks
            hb_rose = e_hb && !hb_old;
            if (hb_rose) begin base = 0; divc = 0; end
            else if (e_hb && wide != 0) begin
                if (divc == 2*int'(wide) - 1) begin divc = 0; base = !base; end
                else divc++;
            end else begin base = !base; divc = 0; end
            g1 = base ^ pa; g2 = base ^ pb; g3 = base ^ pc;
            if (mode == 3'b001)      e_h = {!g1, g1, !g1, g1};
            else if (mode == 3'b010) e_h = {g2, g1, g2, g1};
            else if (mode == 3'b100) e_h = {!g3, g3, !g1, g1};
            else begin e_h = 0; e_err = 1; end
            if ((mode == 3'b001 || mode == 3'b010 || mode == 3'b100) && e_hb && wide == 0)
                e_h = {mk24, mk13, mk24, mk13};
            sp = s2; s2 = s1; s1 = hd;
        end
        #2;
        if (rst_n && !done) begin
            check("R4 clamp", clamp, e_clp);
            check("R4 preblank", pblk, e_pblk);
            check("R5 hblank", hblank, e_hb);
            if (hb_rose)               check("R10 hclk", hclk, e_h);
            else if (!e_hb)            check("R6 hclk", hclk, e_h);
            else if (wide == 0)        check("R7 hclk", hclk, e_h);
            else                       check("R8 hclk", hclk, e_h);
            check("R9 err", merr, e_err);
        end
    end

    task automatic run_line(input int len);
        @(negedge clk); hd = 0; fodd = !fodd;
        repeat (3) @(negedge clk);
        hd = 1;
        repeat (len - 4) @(negedge clk);
    endtask

    bit mon_on = 0;
    int mon_zero = 0;
    always @(posedge clk) begin
        #3;
        if (mon_on && !clamp) mon_zero++;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 clamp", clamp, 0);
        check("R1 hclk", hclk, 0);
        check("R1 err", merr, 0);
        @(negedge clk); rst_n = 1;

        // scenario A: mode 001, masks, odd/even blank sets
        clp_pos  = {13'd30, 13'd20};
        pblk_pol = 1; pblk_pos = {13'd40, 13'd5};
        hbo_pos  = {13'd0, 13'd0, 13'd0, 13'd80, 13'd70, 13'd50}; hbo_en = 6'b000111;
        hbe_pos  = {13'd0, 13'd0, 13'd0, 13'd0, 13'd75, 13'd60};  hbe_en = 6'b000011;
        mk13 = 1; mk24 = 0; pa = 1;
        repeat (10) @(negedge clk);
        check("R1 clamp idle", clamp, 0);
        check("R1 hblank idle", hblank, 0);

        // first line, timed: strobe sampled low at edge n
        hd = 0; fodd = 1;
        for (int k = 0; k < 22; k++) begin
            @(posedge clk); #2;
            if (k == 2)  hd = 1;
            if (k == 12) check("R2 preblank before restart", pblk, 0);
            if (k == 13) check("R2 preblank at restart", pblk, 1);
            if (k == 18) check("R3 preblank before pos 5", pblk, 1);
            if (k == 19) check("R3 preblank at pos 5", pblk, 0);
        end
        repeat (100) @(negedge clk);
        for (int l = 0; l < 5; l++) run_line(120);

        // scenario B: mode 010, wide 3
        mode = 3'b010; pb = 1; wide = 3;
        for (int l = 0; l < 4; l++) run_line(130);

        // scenario C: mode 100, wide 1, coinciding clamp positions
        mode = 3'b100; pc = 1; wide = 1; clp_pos = {13'd25, 13'd25};
        for (int l = 0; l < 4; l++) run_line(110);

        // scenario C2: mode 100, parked masks
        wide = 0; mk13 = 0; mk24 = 1;
        for (int l = 0; l < 3; l++) run_line(110);

        // scenario D: positions inside the restart window never fire
        clp_pol = 1; clp_pos = {13'd95, 13'd90};
        run_line(100);
        mon_on = 1;
        for (int l = 0; l < 3; l++) run_line(100);
        mon_on = 0;
        check("R3 window clamp low cycles", mon_zero, 0);
        run_line(100);

        // scenario E: invalid mode
        mode = 3'b011;
        repeat (5) @(negedge clk);
        check("R9 invalid hclk", hclk, 0);
        check("R9 invalid err", merr, 1);
        mode = 3'b001;
        repeat (5) @(negedge clk);
        check("R9 err sticky", merr, 1);
        rst_n = 0;
        @(negedge clk);
        check("R1 err cleared", merr, 0);
        check("R1 hblank reset", hblank, 0);
        @(negedge clk); rst_n = 1;
        run_line(120);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule